// File: doc/BRIEF.md
# Receive System-Side Slave Timing Port

This block shifts received frame content out onto a serial system bus whose bit clock and frame pulse are both supplied by the system side. The system clock and frame pulse are oversampled in the block's own core clock domain. Control inputs set which system clock edge samples the frame pulse and which edge updates the outputs, and whether the frame pulse is active high or active low. Further inputs select a 1.544 Mb/s bus (193-bit frames) or a 2.048 Mb/s bus (256-bit frames). At 2.048 Mb/s the system clock may run at the bit rate or at twice the bit rate.

For each bit position, the block names the timeslot it is about to send on `slot_idx`. The content source answers combinationally with that slot's byte and its four signaling bits. The block then drives the data serially, MSB first. Signaling is emitted in the same slot as its data.

The block also measures the spacing between frame pulses. Spacing must be a whole number of frame lengths, counted in frame-sampling edges. A pulse at any other spacing raises a sticky alarm, which can be routed to an interrupt.

Top module: `rxs_slave_port`

## Requirements
- R1: After reset, `ser_data`, `ser_sig`, `spacing_alarm` and `irq` are all 0.
- R2: With `fp_low_active`=0 the frame pulse is active high, and with 1 it is active low. A pulse is a change from the inactive to the active level, as seen on successive frame-sampling edges.
- R3: The frame pulse is sampled on the falling system clock edge when `fp_edge_fall`=1 and on the rising edge otherwise. Outputs update only on the edge selected in the same way by `dat_edge_fall`. When the two selections are equal, the update on the sampling edge carries frame bit 0. When they differ, the pulse counts as arriving early, and the next update edge carries bit 0.
- R4: With `rate_2m`=1 a frame has 256 bits: 32 slots of 8 bits each, slot n in bits 8n..8n+7. With `rate_2m`=0 a frame has 193 bits: bit 0 is the `f_bit` input, and slot n (0..23) occupies bits 8n+1..8n+8. Each byte is sent MSB first.
- R5: With `rate_2m`=1 and `clk_double`=1 there are two selected edges per bit. The first is the edge marked by the frame pulse. Outputs update on the first of the two edges when `upd_second`=0 and on the second when it is 1. With `rate_2m`=0, `clk_double` has no effect.
- R6: `ser_sig` carries `slot_sig[3]`, `[2]`, `[1]`, `[0]` on bits 4, 5, 6, 7 of each slot (counting 0 = MSB). It is 0 on slot bits 0 to 3 and on the 193-bit frame's F bit.
- R7: A pulse whose spacing from the previous pulse is not a multiple of the frame length sets `spacing_alarm`. Spacing is counted in frame-sampling edges, and the frame length in those edges is 193, 256 or 512. The first pulse after reset is never flagged. A flagged pulse does not realign the bit position.
- R8: `spacing_alarm` stays set until a one-cycle `alarm_clr` strobe. If a flagged pulse and the strobe fall in the same core cycle, the alarm stays set.
- R9: `irq` is 1 exactly when `spacing_alarm` is 1 and `alarm_en` is 1.
- R10: Every accepted pulse restarts the frame at bit 0, wherever the free-running bit position stood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times faster than the system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_ck | input | 1 | System-side bit clock |
| sys_fp | input | 1 | System-side frame pulse |
| fp_edge_fall | input | 1 | 1: sample the frame pulse on the falling edge |
| dat_edge_fall | input | 1 | 1: update outputs on the falling edge |
| fp_low_active | input | 1 | 1: frame pulse is active low |
| rate_2m | input | 1 | 1: 2.048 Mb/s bus, 0: 1.544 Mb/s bus |
| clk_double | input | 1 | 1: system clock at twice the bit rate (2.048 Mb/s only) |
| upd_second | input | 1 | In double-rate mode, update on the second edge of each bit |
| f_bit | input | 1 | Value sent in the F bit of a 193-bit frame |
| slot_byte | input | 8 | Data byte of the slot named by `slot_idx` |
| slot_sig | input | 4 | Signaling bits of the slot named by `slot_idx` |
| alarm_en | input | 1 | Routes the spacing alarm to `irq` |
| alarm_clr | input | 1 | Write-one-to-clear strobe for the alarm |
| slot_idx | output | 5 | Slot whose content is requested this cycle |
| ser_data | output | 1 | Serial data out |
| ser_sig | output | 1 | Serial signaling out |
| spacing_alarm | output | 1 | Sticky frame pulse spacing alarm |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet in one core cycle.

The first pair is the alarm being set by a badly spaced pulse and software clearing it. The bench places the `alarm_clr` strobe on exactly the core cycle in which the delayed sampling edge of a misplaced pulse is seen. The alarm must then read 1 afterwards, while a lone strobe must clear it.

The second pair is frame pulse sampling and data update when both edge selections match. Bit 0 must then appear on that same edge. The behavioural model compares every output after every system clock half period.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } sys_edge_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_evt_t;

   function automatic logic pick_evt(edge_evt_t e, sys_edge_e sel);
      return (sel == EDGE_FALL) ? e.fall : e.rise;
   endfunction

endpackage

// File: rtl/rxs_edge_sync.sv
module rxs_edge_sync
   import rxs_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sys_ck,
   input  logic      sys_fp,
   output edge_evt_t evt,
   output logic      fp_lvl
);

   // clock and frame pulse travel through matched chains so that the
   // pulse level seen with an edge is the level present at that edge
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic ck_q;
      logic fp_q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_q <= 1'b0;
               fp_q <= 1'b0;
            end else begin
               ck_q <= sys_ck;
               fp_q <= sys_fp;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ck_q <= 1'b0;
               fp_q <= 1'b0;
            end else begin
               ck_q <= g_stage[g-1].ck_q;
               fp_q <= g_stage[g-1].fp_q;
            end
         end
      end
   end

   logic ck_last;
   logic ck_prev;

   assign ck_last = g_stage[STAGES-1].ck_q;
   assign fp_lvl  = g_stage[STAGES-1].fp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_prev <= 1'b0;
      else        ck_prev <= ck_last;
   end

   assign evt.rise = ck_last & ~ck_prev;
   assign evt.fall = ~ck_last & ck_prev;

endmodule

// File: rtl/rxs_frame_watch.sv
module rxs_frame_watch #(
   parameter int POS_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fp_evt,
   input  logic             fp_lvl,
   input  logic             fp_low_active,
   input  logic [POS_W-1:0] frame_len,
   input  logic             alarm_clr,
   output logic             pulse_ok,
   output logic             spacing_alarm
);

   logic             prev_act;
   logic             have_ref;
   logic [POS_W-1:0] spm;
   logic [POS_W-1:0] len_m1;
   logic             act;
   logic             pulse;
   logic             bad;

   assign len_m1   = frame_len - POS_W'(1);
   assign act      = fp_lvl ^ fp_low_active;
   assign pulse    = fp_evt & act & ~prev_act;
   // spm counts sampling edges since the last pulse, modulo the frame length
   assign bad      = have_ref & (spm != len_m1);
   assign pulse_ok = pulse & ~bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_act <= 1'b0;
         have_ref <= 1'b0;
         spm      <= '0;
      end else if (fp_evt) begin
         prev_act <= act;
         if (pulse) begin
            spm      <= '0;
            have_ref <= 1'b1;
         end else if (spm >= len_m1) begin
            spm <= '0;
         end else begin
            spm <= spm + POS_W'(1);
         end
      end
   end

   // setting takes precedence over a simultaneous clear strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             spacing_alarm <= 1'b0;
      else if (pulse && bad)  spacing_alarm <= 1'b1;
      else if (alarm_clr)     spacing_alarm <= 1'b0;
   end

endmodule

// File: rtl/rxs_bit_timer.sv
module rxs_bit_timer #(
   parameter int POS_W  = 10,
   parameter int SLOT_W = 5,
   parameter int BYTE_W = 8,
   parameter int SIG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_evt,
   input  logic              pulse_ok,
   input  logic              same_edge,
   input  logic              dbl,
   input  logic              upd_second,
   input  logic              t1_mode,
   input  logic [POS_W-1:0]  frame_len,
   input  logic              f_bit,
   input  logic [BYTE_W-1:0] slot_byte,
   input  logic [SIG_W-1:0]  slot_sig,
   output logic [POS_W-1:0]  pos,
   output logic [SLOT_W-1:0] slot_idx,
   output logic              upd_fire,
   output logic              ser_data,
   output logic              ser_sig
);

   localparam int BP_W  = $clog2(BYTE_W);
   localparam int SIG_B = $clog2(SIG_W);

   logic             align_req;
   logic             do_align;
   logic [POS_W-1:0] pos_nxt;
   logic [POS_W-1:0] bit_ix;
   logic [POS_W-1:0] in_slots;
   logic             is_fbit;
   logic [BP_W-1:0]  bp;
   logic [BP_W-1:0]  inv_bp;
   logic             sig_zone;

   // an early pulse (edges differ) waits here for the next update edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      align_req <= 1'b0;
      else if (pulse_ok && !same_edge) align_req <= 1'b1;
      else if (dat_evt)                align_req <= 1'b0;
   end

   assign do_align = align_req | (pulse_ok & same_edge);

   always_comb begin
      if (do_align)                          pos_nxt = '0;
      else if (pos >= frame_len - POS_W'(1)) pos_nxt = '0;
      else                                   pos_nxt = pos + POS_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pos <= '0;
      else if (dat_evt) pos <= pos_nxt;
   end

   // double-rate clock: position counts half bits, LSB is the edge phase
   assign bit_ix   = dbl ? (pos_nxt >> 1) : pos_nxt;
   assign upd_fire = dat_evt & (~dbl | (pos_nxt[0] == upd_second));
   assign is_fbit  = t1_mode & (bit_ix == '0);
   assign in_slots = t1_mode ? (bit_ix - POS_W'(1)) : bit_ix;
   assign bp       = in_slots[BP_W-1:0];
   assign inv_bp   = ~bp;
   assign sig_zone = (inv_bp < BP_W'(SIG_W));
   assign slot_idx = is_fbit ? '0 : SLOT_W'(in_slots >> BP_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_data <= 1'b0;
         ser_sig  <= 1'b0;
      end else if (upd_fire) begin
         if (is_fbit) begin
            ser_data <= f_bit;
            ser_sig  <= 1'b0;
         end else begin
            ser_data <= slot_byte[inv_bp];
            ser_sig  <= sig_zone ? slot_sig[inv_bp[SIG_B-1:0]] : 1'b0;
         end
      end
   end

endmodule

// File: rtl/rxs_slave_port.sv
module rxs_slave_port
   import rxs_pkg::*;
#(
   parameter int  BITS_T1     = 193,
   parameter int  BITS_E1     = 256,
   parameter int  BYTE_W      = 8,
   parameter int  SIG_W       = 4,
   parameter int  SYNC_STAGES = 2,
   localparam int POS_W       = $clog2(2 * BITS_E1) + 1,
   localparam int SLOT_W      = $clog2(BITS_E1 / BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sys_ck,
   input  logic              sys_fp,
   input  logic              fp_edge_fall,
   input  logic              dat_edge_fall,
   input  logic              fp_low_active,
   input  logic              rate_2m,
   input  logic              clk_double,
   input  logic              upd_second,
   input  logic              f_bit,
   input  logic [BYTE_W-1:0] slot_byte,
   input  logic [SIG_W-1:0]  slot_sig,
   input  logic              alarm_en,
   input  logic              alarm_clr,
   output logic [SLOT_W-1:0] slot_idx,
   output logic              ser_data,
   output logic              ser_sig,
   output logic              spacing_alarm,
   output logic              irq
);

   // elaboration-time parameter checks
   if (BYTE_W < 4 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte
      $error("BYTE_W must be a power of two, at least 4");
   end
   if (SIG_W < 2 || SIG_W >= BYTE_W || (SIG_W & (SIG_W - 1)) != 0) begin : g_bad_sig
      $error("SIG_W must be a power of two between 2 and BYTE_W/2");
   end
   if (BITS_E1 % BYTE_W != 0) begin : g_bad_e1
      $error("BITS_E1 must hold whole slots");
   end
   if ((BITS_T1 - 1) % BYTE_W != 0 || BITS_T1 >= BITS_E1) begin : g_bad_t1
      $error("BITS_T1 must be one F bit plus whole slots, shorter than BITS_E1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   edge_evt_t        evt;
   logic             fp_lvl;
   logic             fp_evt;
   logic             dat_evt;
   logic             same_edge;
   logic             dbl;
   logic             t1_mode;
   logic [POS_W-1:0] frame_len;
   logic             pulse_ok;
   logic             upd_fire;
   logic [POS_W-1:0] pos;

   assign fp_evt    = pick_evt(evt, sys_edge_e'(fp_edge_fall));
   assign dat_evt   = pick_evt(evt, sys_edge_e'(dat_edge_fall));
   assign same_edge = (fp_edge_fall == dat_edge_fall);
   assign t1_mode   = ~rate_2m;
   assign dbl       = clk_double & rate_2m;
   assign frame_len = t1_mode ? POS_W'(BITS_T1)
                    : (dbl ? POS_W'(2 * BITS_E1) : POS_W'(BITS_E1));

   rxs_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sys_ck (sys_ck),
      .sys_fp (sys_fp),
      .evt    (evt),
      .fp_lvl (fp_lvl)
   );

   rxs_frame_watch #(
      .POS_W (POS_W)
   ) u_watch (
      .clk           (clk),
      .rst_n         (rst_n),
      .fp_evt        (fp_evt),
      .fp_lvl        (fp_lvl),
      .fp_low_active (fp_low_active),
      .frame_len     (frame_len),
      .alarm_clr     (alarm_clr),
      .pulse_ok      (pulse_ok),
      .spacing_alarm (spacing_alarm)
   );

   rxs_bit_timer #(
      .POS_W  (POS_W),
      .SLOT_W (SLOT_W),
      .BYTE_W (BYTE_W),
      .SIG_W  (SIG_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .dat_evt    (dat_evt),
      .pulse_ok   (pulse_ok),
      .same_edge  (same_edge),
      .dbl        (dbl),
      .upd_second (upd_second),
      .t1_mode    (t1_mode),
      .frame_len  (frame_len),
      .f_bit      (f_bit),
      .slot_byte  (slot_byte),
      .slot_sig   (slot_sig),
      .pos        (pos),
      .slot_idx   (slot_idx),
      .upd_fire   (upd_fire),
      .ser_data   (ser_data),
      .ser_sig    (ser_sig)
   );

   assign irq = spacing_alarm & alarm_en;

endmodule

// File: rtl/rxs_slave_port_chk.sv
module rxs_slave_port_chk #(
   parameter int POS_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             spacing_alarm,
   input logic             alarm_clr,
   input logic             alarm_en,
   input logic             irq,
   input logic             ser_data,
   input logic             ser_sig,
   input logic             upd_fire,
   input logic             dat_evt,
   input logic             pulse_ok,
   input logic             same_edge,
   input logic [POS_W-1:0] pos,
   input logic [POS_W-1:0] frame_len
);

   assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_fire |=> $stable(ser_data));

   assert_sig_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_fire |=> $stable(ser_sig));

   assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dat_evt |=> (pos < $past(frame_len)));

   assert_realign_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_ok && same_edge) |=> (pos == '0));

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (spacing_alarm && !alarm_clr) |=> spacing_alarm);

   assert_fall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spacing_alarm) |-> $past(alarm_clr));

   assert_irq_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> alarm_en);

   assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> spacing_alarm);

endmodule

bind rxs_slave_port rxs_slave_port_chk #(.POS_W(POS_W)) u_chk (.*);

// File: tb/rxs_slave_port_test.sv
module rxs_slave_port_test;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sys_ck = 1'b0, sys_fp = 1'b0;
   logic       fp_edge_fall = 1'b0, dat_edge_fall = 1'b0, fp_low_active = 1'b0;
   logic       rate_2m = 1'b1, clk_double = 1'b0, upd_second = 1'b0;
   logic       f_bit = 1'b1, alarm_en = 1'b1, alarm_clr = 1'b0;
   logic [4:0] slot_idx;
   logic [7:0] slot_byte;
   logic [3:0] slot_sig;
   logic       ser_data, ser_sig, spacing_alarm, irq;

   int n_chk = 0;
   int n_fail = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] byte_of(int s);
      return 8'((s * 37 + 5) % 256);
   endfunction
   function automatic logic [3:0] sig_of(int s);
      return 4'((s ^ 10) & 15);
   endfunction

   assign slot_byte = byte_of(int'(slot_idx));
   assign slot_sig  = sig_of(int'(slot_idx));

   rxs_slave_port uut (
      .clk(clk), .rst_n(rst_n), .sys_ck(sys_ck), .sys_fp(sys_fp),
      .fp_edge_fall(fp_edge_fall), .dat_edge_fall(dat_edge_fall),
      .fp_low_active(fp_low_active), .rate_2m(rate_2m), .clk_double(clk_double),
      .upd_second(upd_second), .f_bit(f_bit), .slot_byte(slot_byte),
      .slot_sig(slot_sig), .alarm_en(alarm_en), .alarm_clr(alarm_clr),
      .slot_idx(slot_idx), .ser_data(ser_data), .ser_sig(ser_sig),
      .spacing_alarm(spacing_alarm), .irq(irq)
   );

   // behavioural reference, advanced once per system clock edge
   int m_pos, m_spm;
   bit m_prev, m_ref, m_pend, m_data, m_sig, m_alarm;

   function automatic int cur_len();
      if (!rate_2m) return 193;
      return (clk_double) ? 512 : 256;
   endfunction

   task automatic model_reset();
      m_pos = 0; m_spm = 0; m_prev = 0; m_ref = 0; m_pend = 0;
      m_data = 0; m_sig = 0; m_alarm = 0;
   endtask

   task automatic model_edge(bit is_fall, bit fp_in, bit clr);
      int L = cur_len();
      bit set_now = 0;
      bit hit_now = 0;
      bit act;
      bit dbl = clk_double & rate_2m;
      int b, k;
      logic [7:0] by;
      logic [3:0] sg;
      if (is_fall == fp_edge_fall) begin
         act = fp_in ^ fp_low_active;
         if (act && !m_prev) begin
            if (m_ref && m_spm != L - 1) set_now = 1;
            else hit_now = 1;
            m_spm = 0;
            m_ref = 1;
         end else begin
            m_spm = (m_spm >= L - 1) ? 0 : m_spm + 1;
         end
         m_prev = act;
         if (hit_now && fp_edge_fall != dat_edge_fall) m_pend = 1;
      end
      if (is_fall == dat_edge_fall) begin
         if (m_pend || hit_now) m_pos = 0;
         else m_pos = (m_pos >= L - 1) ? 0 : m_pos + 1;
         m_pend = 0;
         if (!dbl || (m_pos % 2) == int'(upd_second)) begin
            b = dbl ? m_pos / 2 : m_pos;
            if (!rate_2m && b == 0) begin
               m_data = f_bit;
               m_sig  = 0;
            end else begin
               k  = rate_2m ? b : b - 1;
               by = byte_of(k / 8);
               sg = sig_of(k / 8);
               m_data = by[7 - (k % 8)];
               m_sig  = ((k % 8) >= 4) ? sg[7 - (k % 8)] : 1'b0;
            end
         end
      end
      if (set_now) m_alarm = 1;
      else if (clr) m_alarm = 0;
   endtask

   task automatic chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(cur_req, "ser_data", ser_data, m_data);
      chk(cur_req, "ser_sig", ser_sig, m_sig);
      chk(cur_req, "spacing_alarm", spacing_alarm, m_alarm);
      chk(cur_req, "irq", irq, m_alarm & alarm_en);
   endtask

   // one system clock half period: 4 core cycles, compared before the next drive
   task automatic half(bit ck, bit fp, bit clr);
      @(negedge clk);
      compare_all();
      sys_ck = ck;
      sys_fp = fp;
      model_edge(!ck, fp, clr);
      @(negedge clk);
      @(negedge clk);
      if (clr) alarm_clr = 1'b1;   // lands on the core cycle that sees the edge
      @(negedge clk);
      alarm_clr = 1'b0;
   endtask

   task automatic cyc(bit p, bit clr_rise, bit clr_fall);
      bit lvl = p ^ fp_low_active;
      half(1'b1, lvl, clr_rise);
      half(1'b0, lvl, clr_fall);
   endtask

   task automatic frames(int gap, int n, int lead);
      repeat (lead) cyc(0, 0, 0);
      repeat (n) begin
         cyc(1, 0, 0);
         repeat (gap - 1) cyc(0, 0, 0);
      end
   endtask

   task automatic setup(bit fpf, bit datf, bit low, bit r2m, bit dbl, bit u2);
      @(negedge clk);
      rst_n = 1'b0;
      fp_edge_fall = fpf; dat_edge_fall = datf; fp_low_active = low;
      rate_2m = r2m; clk_double = dbl; upd_second = u2;
      sys_ck = 1'b0; sys_fp = low; alarm_clr = 1'b0;
      repeat (4) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
   endtask

   initial begin
      // R1: reset values
      setup(0, 0, 0, 1, 0, 0);
      @(negedge clk);
      chk("R1", "ser_data", ser_data, 1'b0);
      chk("R1", "ser_sig", ser_sig, 1'b0);
      chk("R1", "spacing_alarm", spacing_alarm, 1'b0);
      chk("R1", "irq", irq, 1'b0);

      // R4/R6: 256-bit frames, both selections on the rising edge
      cur_req = "R4";
      frames(256, 3, 0);

      // R10: free-running counter realigned by the first pulse
      cur_req = "R10";
      setup(0, 0, 0, 1, 0, 0);
      frames(256, 2, 37);

      // R3: pulse sampled on falling edge, data on rising (pulse early)
      cur_req = "R3";
      setup(1, 0, 0, 1, 0, 0);
      frames(256, 2, 5);
      // R3: sampled on rising, data on falling
      setup(0, 1, 0, 1, 0, 0);
      frames(256, 2, 3);

      // R2: active-low frame pulse
      cur_req = "R2";
      setup(0, 0, 1, 1, 0, 0);
      frames(256, 2, 11);

      // R4/R6: 193-bit frames with F bit
      cur_req = "R6";
      setup(0, 0, 0, 0, 0, 0);
      frames(193, 2, 7);
      f_bit = 1'b0;
      frames(193, 1, 0);
      f_bit = 1'b1;

      // R5: double-rate clock, first and second edge update
      cur_req = "R5";
      setup(0, 0, 0, 1, 1, 0);
      frames(512, 2, 9);
      setup(1, 0, 0, 1, 1, 1);
      frames(512, 2, 4);
      // R5: double-rate request ignored at 1.544 Mb/s
      setup(0, 0, 0, 0, 1, 1);
      frames(193, 2, 2);

      // R7: spacing of two frames is valid
      cur_req = "R7";
      setup(0, 0, 0, 1, 0, 0);
      frames(512, 2, 0);
      @(negedge clk);
      chk("R7", "alarm after 2-frame spacing", spacing_alarm, 1'b0);
      // R7: misplaced pulse flags alarm and does not realign
      alarm_en = 1'b0;
      repeat (99) cyc(0, 0, 0);
      frames(256, 1, 0);
      @(negedge clk);
      chk("R7", "alarm after bad spacing", spacing_alarm, 1'b1);
      // R9: interrupt gated by the enable
      chk("R9", "irq with enable off", irq, 1'b0);
      alarm_en = 1'b1;
      @(negedge clk);
      chk("R9", "irq with enable on", irq, 1'b1);

      // R8: lone clear strobe clears the alarm
      cur_req = "R8";
      cyc(0, 1, 0);
      chk("R8", "alarm after clear", spacing_alarm, 1'b0);
      // R8: clear in the same cycle as a bad pulse: alarm stays set
      repeat (40) cyc(0, 0, 0);
      cyc(1, 1, 0);
      chk("R8", "alarm after set+clear collision", spacing_alarm, 1'b1);
      repeat (10) cyc(0, 0, 0);
      // R8: collision with the pulse sampled on the falling edge
      setup(1, 0, 0, 1, 0, 0);
      frames(256, 1, 3);
      repeat (17) cyc(0, 0, 0);
      cyc(1, 0, 1);
      chk("R8", "alarm after falling-edge collision", spacing_alarm, 1'b1);
      repeat (4) cyc(0, 0, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule